// File: doc/BRIEF.md
# Windowed Watchdog with Keyed Service

This block is a down-counting watchdog timer that software controls through a small synchronous register port. Software loads a reload value, picks the size of the open window and the reaction, and then arms the timer by writing a 32-bit magic word to the control register. After that the timer can never be stopped again. Each period, software must service the timer with a two-word key sequence. The service counts only if it completes while the counter sits inside the open window. The open window is the last fraction of the period.

A service that completes before the window opens is a fault. A counter that runs down to zero without a service is also a fault. Either fault sets a sticky flag, forces the counter to zero and sends out a single-cycle pulse. The pulse goes on one of two lines, chosen by the reaction register: a reset request or a non-maskable interrupt. Software clears the flag by writing a one to it, and that write also restarts the period.

The register port takes one access per cycle and has no back-pressure. A write takes effect at the clock edge where it is sampled. Read data returns on `rd_data`, with `rd_valid` high, in the cycle after `rd_en`. There is no valid/ready stream at the edge of the block, so nothing can stall.

Top module: `win_watchdog`

## Requirements
- R1: After reset the timer is disarmed. Counter, status, reaction code and window code all read 0, the reload register reads 0xFFF, and both violation outputs are low.
- R2: A write of exactly 0xA98559DA to control (offset 0x90) arms the timer and loads the counter with reload << PRELOAD_SHIFT. Any other value leaves it disarmed with the counter at 0. While the timer is disarmed, no violation pulse is produced.
- R3: Once armed, the timer stays armed: later control writes of any value neither disarm it nor reload the counter. Status bit 0 (offset 0x98) reads 1 while armed.
- R4: While armed and with no flag set, the counter falls by one each cycle. In a cycle where it reads 0 and no valid service completes, the next edge sets the flag and emits a violation pulse.
- R5: A service is the word 0x0000E51A written to key (offset 0x9C), followed by the word 0x0000A35C. When the second word lands inside the window, the counter reloads. Any key word other than the expected next one returns the sequence to its start without a reload. Key writes while disarmed, or while the flag is set, have no effect.
- R6: Window code (offset 0xA8) 0x50, 0x28, 0x14, 0x0A or 0x05 makes the window the final 1/2, 1/4, 1/8, 1/16 or 1/32 of the period. A service is legal when the counter is at or below (reload << PRELOAD_SHIFT) >> k, for k = 1 to 5 respectively. Any other code leaves the window open for the whole period.
- R7: A service that completes above the window bound sets the flag, emits a violation pulse and forces the counter to 0.
- R8: Reaction code 0x0A (offset 0xA4) sends violations to `nmi_pulse`, and any other code sends them to `rst_req_pulse`. Each violation gives exactly one one-cycle pulse on exactly one of the two lines.
- R9: Status bit 1 is the sticky violation flag. Writing status with bit 1 set clears the flag and restarts the counter from the reload value. Writing with bit 1 clear changes nothing.
- R10: `rd_data` carries, one cycle after `rd_en`, the value of the addressed register: counter at 0xA0, reload at 0x94, control bit 0 = armed. The counter reads 0 while the flag is set. Key and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| rd_valid | output | 1 | High when rd_data holds a read result |
| rst_req_pulse | output | 1 | One-cycle reset request on violation |
| nmi_pulse | output | 1 | One-cycle interrupt on violation |

## Verification
The assertions rely on one fact about the inputs: one register access per cycle, with a write and a read never sampled together in a way that matters. They also assume that nothing can clear the flag in the same cycle that sets it. A clear needs a status write, and such a write only acts while the flag is already set. The stimulus drives one access at a time on the falling edge and holds each strobe for exactly one cycle. It waits on the bench's own model of the counter before placing services in or outside the window. Clears are only issued after the flag is seen set.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned CODE_W    = 8;
  localparam int unsigned WIN_STEPS = 5;

  // offsets that software decodes
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h90;
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 8'h94;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h98;
  localparam logic [ADDR_W-1:0] OFS_KEY    = 8'h9C;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'hA0;
  localparam logic [ADDR_W-1:0] OFS_REACT  = 8'hA4;
  localparam logic [ADDR_W-1:0] OFS_WIN    = 8'hA8;

  localparam logic [WORD_W-1:0] ARM_WORD   = 32'hA98559DA;
  localparam logic [WORD_W-1:0] KEY_FIRST  = 32'h0000E51A;
  localparam logic [WORD_W-1:0] KEY_SECOND = 32'h0000A35C;
  localparam logic [CODE_W-1:0] REACT_IRQ  = 8'h0A;
  localparam logic [CODE_W-1:0] WIN_HALF   = 8'h50;  // each narrower step halves the code

  typedef enum logic {KEY_IDLE, KEY_ARMED} key_state_e;
endpackage

// File: rtl/wdt_window.sv
module wdt_window
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 25
) (
  input  logic [CODE_W-1:0] win_code,
  input  logic [CNT_W-1:0]  reload,
  output logic [CNT_W-1:0]  bound
);
  logic [WIN_STEPS-1:0] hit;
  logic [CNT_W-1:0]     cand [WIN_STEPS];

  for (genvar g = 0; g < WIN_STEPS; g++) begin : g_step
    assign hit[g]  = (win_code == (WIN_HALF >> g));
    assign cand[g] = reload >> (g + 1);
  end

  always_comb begin
    bound = reload;  // unknown code: whole period open
    for (int i = 0; i < WIN_STEPS; i++) begin
      if (hit[i]) bound = cand[i];
    end
  end
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              flagged,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              svc_req
);
  key_state_e state_q;
  logic       key_wr;

  assign key_wr  = armed && !flagged && wr_en && (addr == OFS_KEY);
  assign svc_req = key_wr && (state_q == KEY_ARMED) && (wr_data == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (!rst_n || !armed || flagged) begin
      state_q <= KEY_IDLE;
    end else if (key_wr) begin
      state_q <= (state_q == KEY_IDLE && wr_data == KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  reload,
  input  logic [CNT_W-1:0]  bound,
  input  logic              svc_req,
  input  logic              to_irq,
  output logic              armed,
  output logic              flagged,
  output logic [CNT_W-1:0]  count,
  output logic              rst_req_pulse,
  output logic              nmi_pulse
);
  logic             armed_d, flag_d, viol;
  logic [CNT_W-1:0] cnt_d;
  logic             arm_wr, clr_wr;

  assign arm_wr = wr_en && (addr == OFS_CTRL) && (wr_data == ARM_WORD);
  assign clr_wr = wr_en && (addr == OFS_STAT) && wr_data[1];

  always_comb begin
    armed_d = armed;
    flag_d  = flagged;
    cnt_d   = count;
    viol    = 1'b0;
    if (!armed) begin
      if (arm_wr) begin
        armed_d = 1'b1;
        cnt_d   = reload;
      end
    end else if (flagged) begin
      if (clr_wr) begin
        flag_d = 1'b0;
        cnt_d  = reload;
      end
    end else if (svc_req) begin
      if (count <= bound) begin
        cnt_d = reload;
      end else begin
        viol   = 1'b1;
        flag_d = 1'b1;
        cnt_d  = '0;
      end
    end else if (count == '0) begin
      viol   = 1'b1;
      flag_d = 1'b1;
    end else begin
      cnt_d = count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed         <= 1'b0;
      flagged       <= 1'b0;
      count         <= '0;
      rst_req_pulse <= 1'b0;
      nmi_pulse     <= 1'b0;
    end else begin
      armed         <= armed_d;
      flagged       <= flag_d;
      count         <= cnt_d;
      rst_req_pulse <= viol && !to_irq;
      nmi_pulse     <= viol && to_irq;
    end
  end
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int unsigned PRELOAD_W = 12,
  parameter int unsigned CNT_W     = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [PRELOAD_W-1:0] wr_pre,
  input  logic [CODE_W-1:0]    wr_code,
  input  logic                 armed,
  input  logic                 flagged,
  input  logic [CNT_W-1:0]     count,
  output logic [PRELOAD_W-1:0] preload,
  output logic [CODE_W-1:0]    win_code,
  output logic [CODE_W-1:0]    react_code,
  output logic [WORD_W-1:0]    rd_data,
  output logic                 rd_valid
);
  logic [WORD_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preload    <= '1;
      win_code   <= '0;
      react_code <= '0;
    end else if (wr_en) begin
      if (addr == OFS_RELOAD) preload    <= wr_pre;
      if (addr == OFS_WIN)    win_code   <= wr_code;
      if (addr == OFS_REACT)  react_code <= wr_code;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      OFS_CTRL:   rd_mux = WORD_W'(armed);
      OFS_RELOAD: rd_mux = WORD_W'(preload);
      OFS_STAT:   rd_mux = WORD_W'({flagged, armed});
      OFS_COUNT:  rd_mux = WORD_W'(count);
      OFS_REACT:  rd_mux = WORD_W'(react_code);
      OFS_WIN:    rd_mux = WORD_W'(win_code);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned PRELOAD_W     = 12,
  parameter int unsigned PRELOAD_SHIFT = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rst_req_pulse,
  output logic              nmi_pulse
);
  localparam int unsigned CNT_W = PRELOAD_W + PRELOAD_SHIFT;

  logic [PRELOAD_W-1:0] preload;
  logic [CODE_W-1:0]    win_code, react_code;
  logic [CNT_W-1:0]     reload, bound, count;
  logic                 armed, flagged, svc_req;

  assign reload = {preload, {PRELOAD_SHIFT{1'b0}}};

  wdt_regfile #(.PRELOAD_W(PRELOAD_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_pre(wr_data[PRELOAD_W-1:0]), .wr_code(wr_data[CODE_W-1:0]),
    .armed(armed), .flagged(flagged), .count(count),
    .preload(preload), .win_code(win_code), .react_code(react_code),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  wdt_window #(.CNT_W(CNT_W)) u_win (
    .win_code(win_code), .reload(reload), .bound(bound)
  );

  wdt_key_seq u_key (
    .clk(clk), .rst_n(rst_n), .armed(armed), .flagged(flagged),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .svc_req(svc_req)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .reload(reload), .bound(bound), .svc_req(svc_req),
    .to_irq(react_code == REACT_IRQ),
    .armed(armed), .flagged(flagged), .count(count),
    .rst_req_pulse(rst_req_pulse), .nmi_pulse(nmi_pulse)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned CNT_W = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             armed,
  input logic             flagged,
  input logic             svc_req,
  input logic [CNT_W-1:0] count,
  input logic             rst_req_pulse,
  input logic             nmi_pulse
);
  assert_one_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req_pulse && nmi_pulse));

  assert_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_pulse || nmi_pulse) |=> !(rst_req_pulse || nmi_pulse));

  assert_pulse_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_pulse || nmi_pulse) |-> flagged);

  assert_arm_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  assert_quiet_disarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !(rst_req_pulse || nmi_pulse));

  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !flagged && !svc_req && count != '0) |=> (count == $past(count) - 1'b1));

  assert_flag_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flagged |-> (count == '0));
endmodule

bind win_watchdog wdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .flagged(flagged), .svc_req(svc_req),
  .count(count), .rst_req_pulse(rst_req_pulse), .nmi_pulse(nmi_pulse)
);

// File: tb/win_watchdog_test.sv
module win_watchdog_test;
  localparam int SHIFT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid, rst_req_pulse, nmi_pulse;

  int n_chk = 0, n_fail = 0, seen_rst = 0, seen_nmi = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  win_watchdog #(.PRELOAD_W(12), .PRELOAD_SHIFT(SHIFT)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .rst_req_pulse(rst_req_pulse), .nmi_pulse(nmi_pulse)
  );

  // behavioural reference
  bit m_arm, m_flag, m_key, m_rst, m_nmi, m_rv;
  int m_cnt, m_pre, m_win, m_react;
  logic [31:0] m_rd;

  function automatic int bound_of(int rl, int code);
    case (code)
      8'h50: return rl / 2;
      8'h28: return rl / 4;
      8'h14: return rl / 8;
      8'h0A: return rl / 16;
      8'h05: return rl / 32;
      default: return rl;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_arm = 0; m_flag = 0; m_key = 0; m_rst = 0; m_nmi = 0; m_rv = 0;
      m_cnt = 0; m_pre = 12'hFFF; m_win = 0; m_react = 0; m_rd = 0;
    end else begin
      int rl;
      bit viol, svc;
      rl = m_pre << SHIFT;
      m_rv = rd_en;
      if (rd_en) begin
        case (addr)
          8'h90: m_rd = {31'd0, m_arm};
          8'h94: m_rd = m_pre;
          8'h98: m_rd = {30'd0, m_flag, m_arm};
          8'hA0: m_rd = m_cnt;
          8'hA4: m_rd = m_react;
          8'hA8: m_rd = m_win;
          default: m_rd = 0;
        endcase
      end
      viol = 0;
      svc = m_arm && !m_flag && wr_en && addr == 8'h9C && m_key && wr_data == 32'hA35C;
      if (!m_arm) begin
        if (wr_en && addr == 8'h90 && wr_data == 32'hA98559DA) begin m_arm = 1; m_cnt = rl; end
      end else if (m_flag) begin
        if (wr_en && addr == 8'h98 && wr_data[1]) begin m_flag = 0; m_cnt = rl; end
      end else if (svc) begin
        if (m_cnt <= bound_of(rl, m_win)) m_cnt = rl;
        else begin viol = 1; m_flag = 1; m_cnt = 0; end
      end else if (m_cnt == 0) begin
        viol = 1; m_flag = 1;
      end else m_cnt = m_cnt - 1;
      m_rst = viol && m_react != 8'h0A;
      m_nmi = viol && m_react == 8'h0A;
      if (!m_arm || m_flag) m_key = 0;
      else if (wr_en && addr == 8'h9C) m_key = !m_key && wr_data == 32'hE51A;
      if (wr_en && addr == 8'h94) m_pre = wr_data[11:0];
      if (wr_en && addr == 8'hA8) m_win = wr_data[7:0];
      if (wr_en && addr == 8'hA4) m_react = wr_data[7:0];
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rst_req_pulse == m_rst, "R8 rst_req_pulse vs model", rst_req_pulse, m_rst);
      chk(nmi_pulse == m_nmi, "R8 nmi_pulse vs model", nmi_pulse, m_nmi);
      chk(rd_valid == m_rv, "R10 rd_valid vs model", rd_valid, m_rv);
      if (rst_req_pulse) seen_rst++;
      if (nmi_pulse) seen_nmi++;
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_exp(logic [7:0] a, logic [31:0] e, string tag);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    chk(rd_valid && rd_data == e, tag, rd_data, e);
  endtask

  task automatic rd_mod(logic [7:0] a, string tag);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    chk(rd_valid && rd_data == m_rd, tag, rd_data, m_rd);
  endtask

  task automatic service();
    wr(8'h9C, 32'hE51A);
    wr(8'h9C, 32'hA35C);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int r0, n0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!rst_req_pulse && !nmi_pulse, "R1 outputs low", {rst_req_pulse, nmi_pulse}, 0);
    rd_exp(8'h94, 32'hFFF, "R1 reload reset");
    rd_exp(8'h98, 0, "R1 status reset");
    rd_exp(8'hA0, 0, "R1 counter reset");
    rd_exp(8'hA4, 0, "R1 reaction reset");
    rd_exp(8'hA8, 0, "R1 window reset");
    // R2 wrong word, keys while disarmed
    wr(8'h90, 32'hA98559DB);
    service();
    rd_exp(8'h98, 0, "R2 still disarmed");
    rd_exp(8'hA0, 0, "R5 keys ignored when disarmed");
    rd_exp(8'h9C, 0, "R10 key reads zero");
    rd_exp(8'h00, 0, "R10 unmapped reads zero");
    // arm
    wr(8'h94, 8);
    wr(8'hA8, 32'h50);
    wr(8'h90, 32'hA98559DA);
    rd_mod(8'hA0, "R2 counter loaded");
    chk(rd_data >= 120 && rd_data <= 128, "R2 load value", rd_data, 128);
    // R3 sticky enable
    wr(8'h90, 0);
    wr(8'h90, 32'hA98559DA);
    rd_exp(8'h90, 1, "R3 control armed");
    rd_mod(8'hA0, "R3 no reload on rewrite");
    // R7 early service -> reset request
    r0 = seen_rst;
    service();
    @(negedge clk);
    chk(seen_rst == r0 + 1, "R7 early service pulse", seen_rst, r0 + 1);
    rd_exp(8'h98, 3, "R7 flag set");
    rd_exp(8'hA0, 0, "R10 counter zero while flagged");
    // R9 clear
    wr(8'h98, 32'h1);
    rd_exp(8'h98, 3, "R9 write without bit1");
    wr(8'h98, 32'h2);
    rd_exp(8'h98, 1, "R9 flag cleared");
    rd_mod(8'hA0, "R9 restarted");
    // R5 legal service in window
    while (m_cnt > 60) @(negedge clk);
    r0 = seen_rst;
    service();
    rd_mod(8'hA0, "R5 reloaded");
    chk(rd_data > 100, "R5 reload value", rd_data, 128);
    chk(seen_rst == r0, "R5 no pulse", seen_rst, r0);
    // R5 broken sequence
    while (m_cnt > 60) @(negedge clk);
    wr(8'h9C, 32'hE51A);
    wr(8'h9C, 32'h1234);
    wr(8'h9C, 32'hA35C);
    rd_mod(8'hA0, "R5 bad sequence");
    chk(rd_data <= 60, "R5 bad sequence no reload", rd_data, 60);
    // R4 expiry to NMI
    wr(8'hA4, 32'h0A);
    n0 = seen_nmi; r0 = seen_rst;
    while (!m_flag) @(negedge clk);
    @(negedge clk);
    chk(seen_nmi == n0 + 1 && seen_rst == r0, "R4 R8 expiry to nmi", seen_nmi, n0 + 1);
    rd_exp(8'hA0, 0, "R4 counter holds zero");
    // R6 quarter window
    wr(8'hA8, 32'h28);
    wr(8'h98, 32'h2);
    while (m_cnt > 50) @(negedge clk);
    n0 = seen_nmi;
    service();
    @(negedge clk);
    chk(seen_nmi == n0 + 1, "R6 outside quarter window", seen_nmi, n0 + 1);
    wr(8'h98, 32'h2);
    while (m_cnt > 28) @(negedge clk);
    n0 = seen_nmi;
    service();
    rd_mod(8'hA0, "R6 inside quarter window");
    chk(seen_nmi == n0, "R6 quarter legal no pulse", seen_nmi, n0);
    // R6 unknown code: full window
    wr(8'hA8, 32'hFF);
    service();
    rd_exp(8'h98, 1, "R6 full window no flag");
    rd_mod(8'hA0, "R6 full window reload");
    repeat (4) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule